// File: doc/BRIEF.md
# Watchdog Timer with Shared Scaler

This block holds a watchdog counter and a single eight-stage scaler that it shares with a general-purpose timer. The whole block runs in the watchdog's own free-running clock domain. A `wdt_tick` enable advances the watchdog counter, so the count keeps going while the main core clock is stopped during sleep. When the watchdog expires, the block raises a one-cycle `reset_req` if the device is awake, or a one-cycle `wake_req` if it is asleep. In both cases it pulls the active-low status flag `to_n` down.

The scaler is routed by `psa_sel`. With `psa_sel` = 1 the scaler sits after the watchdog counter and stretches the time-out period, and timer source pulses pass straight through to `tmr_inc`. With `psa_sel` = 0 the scaler divides the timer source pulses, and the watchdog overflow is the time-out with no scaling. The `rate` field picks which scaler stage drives the scaled output. The clear strobe `clr_wdt` and the sleep strobe `sleep_cmd` restart the watchdog. They clear the scaler count only when the scaler belongs to the watchdog.

Top module: `wdt_shared_scaler`

## Requirements
- R1: While `wdt_en` = 1, each cycle with `wdt_tick` = 1 advances a BASE_W-bit counter. With `psa_sel` = 0, a time-out occurs on the 2^BASE_W-th tick after a clear.
- R2: A time-out while `asleep` = 0 produces `reset_req` = 1 for exactly one cycle, in the cycle after the expiring tick, with `wake_req` held at 0.
- R3: A time-out while `asleep` = 1 produces a one-cycle `wake_req` and no `reset_req`.
- R4: `to_n` is 1 after reset and after any `clr_wdt` or `sleep_cmd` strobe. A time-out drives it to 0.
- R5: With `wdt_en` = 0 the counter does not advance and no time-out, reset request or wake request occurs.
- R6: With `psa_sel` = 1, the time-out occurs on tick 2^BASE_W * 2^(rate+1) after a clear, and `tmr_inc` equals `tmr_src` in the same cycle.
- R7: With `psa_sel` = 0, `tmr_inc` pulses in the same cycle as every 2^(rate+1)-th `tmr_src` pulse, counted from a cleared scaler.
- R8: `clr_wdt` and `sleep_cmd` clear the watchdog counter. They clear the scaler only when `psa_sel` = 1, and leave a timer division in progress intact when `psa_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog oscillator clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| wdt_tick | input | 1 | Watchdog count enable |
| tmr_src | input | 1 | Timer clock-source pulse |
| wdt_en | input | 1 | Permanent watchdog enable |
| psa_sel | input | 1 | Scaler assignment: 1 = watchdog, 0 = timer |
| rate | input | 3 | Scaler stage select, division 2^(rate+1) |
| clr_wdt | input | 1 | Clear-watchdog strobe |
| sleep_cmd | input | 1 | Sleep-entry strobe |
| asleep | input | 1 | Device is in sleep |
| reset_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake request |
| to_n | output | 1 | Time-out status, low after a time-out |
| tmr_inc | output | 1 | Timer increment pulse |

## Verification
The assertions check on every cycle that reset and wake requests never coincide and last a single cycle. They also check that a disabled watchdog raises neither request, that a strobe restores `to_n`, that a request implies a low `to_n`, and that `tmr_inc` never fires without a source pulse. The exact time-out periods need the bench's scenarios: every rate with the scaler on the watchdog, the unscaled period, and every timer division. So do the asymmetric effect of a clear on the scaler, depending on its assignment, and the choice between reset and wake.

// File: rtl/wdt_shared_scaler.sv
module wdt_shared_scaler #(
  parameter int BASE_W = 8,
  parameter int SCL_N  = 8,
  localparam int RATE_W = $clog2(SCL_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wdt_tick,
  input  logic              tmr_src,
  input  logic              wdt_en,
  input  logic              psa_sel,
  input  logic [RATE_W-1:0] rate,
  input  logic              clr_wdt,
  input  logic              sleep_cmd,
  input  logic              asleep,
  output logic              reset_req,
  output logic              wake_req,
  output logic              to_n,
  output logic              tmr_inc
);

  logic [BASE_W-1:0] base_q;
  logic [SCL_N-1:0]  scl_q;
  logic [SCL_N-1:0]  tap_mask;
  logic              clr, base_ovf, scl_in, scl_hit, timeout;

  assign clr      = clr_wdt | sleep_cmd;
  assign base_ovf = wdt_en & wdt_tick & ~clr & (&base_q);
  assign scl_in   = psa_sel ? base_ovf : tmr_src;
  assign tap_mask = SCL_N'((32'd2 << rate) - 32'd1);
  assign scl_hit  = scl_in & ((scl_q & tap_mask) == tap_mask);
  assign timeout  = psa_sel ? scl_hit : base_ovf;
  assign tmr_inc  = psa_sel ? tmr_src : scl_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 base_q <= '0;
    else if (!wdt_en || clr)    base_q <= '0;
    else if (wdt_tick)          base_q <= base_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 scl_q <= '0;
    else if (psa_sel && clr)    scl_q <= '0;
    else if (scl_in)            scl_q <= scl_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req <= 1'b0;
      wake_req  <= 1'b0;
      to_n      <= 1'b1;
    end else begin
      reset_req <= timeout & ~asleep;
      wake_req  <= timeout & asleep;
      if (clr)          to_n <= 1'b1;
      else if (timeout) to_n <= 1'b0;
    end
  end

  a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reset_req && wake_req));
  a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);
  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |=> !wake_req);
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> (!reset_req && !wake_req));
  a_r4_strobe_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wdt || sleep_cmd) |=> to_n);
  a_r4_request_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_req || wake_req) |-> !to_n);
  a_r7_no_spurious_inc: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_src |-> !tmr_inc);

endmodule

// File: tb/tb_wdt_shared_scaler.sv
`timescale 1ns/1ps
module tb_wdt_shared_scaler;
  localparam int BW = 4;
  localparam int BASEP = 1 << BW;

  logic clk = 0, rst_n = 0;
  logic wdt_tick = 0, tmr_src = 0, wdt_en = 1, psa_sel = 0;
  logic [2:0] rate = 0;
  logic clr_wdt = 0, sleep_cmd = 0, asleep = 0;
  logic reset_req, wake_req, to_n, tmr_inc;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  wdt_shared_scaler #(.BASE_W(BW), .SCL_N(8)) dut (
    .clk, .rst_n, .wdt_tick, .tmr_src, .wdt_en, .psa_sel, .rate,
    .clr_wdt, .sleep_cmd, .asleep, .reset_req, .wake_req, .to_n, .tmr_inc);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic use_sleep);
    @(negedge clk);
    if (use_sleep) sleep_cmd = 1; else clr_wdt = 1;
    @(negedge clk);
    sleep_cmd = 0; clr_wdt = 0;
    chk("R4 flag set by strobe", to_n, 1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wdt_tick = 1;
    end
    @(negedge clk); wdt_tick = 0;
  endtask

  task automatic measure(input int limit, output int n, output logic rq, output logic wk);
    n = 0; rq = 0; wk = 0;
    wdt_tick = 1;
    while (n < limit && !rq && !wk) begin
      @(negedge clk);
      n++;
      rq = reset_req; wk = wake_req;
    end
    wdt_tick = 0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n; logic rq, wk;
    #35 rst_n = 1;
    @(negedge clk);
    chk("R4 reset flag", to_n, 1);
    chk("R2 reset req idle", reset_req, 0);
    chk("R3 wake req idle", wake_req, 0);

    // R1 R2 unscaled period
    psa_sel = 0;
    strobe(0);
    measure(BASEP + 50, n, rq, wk);
    chk("R1 unscaled period", n, BASEP);
    chk("R2 reset raised", rq, 1);
    chk("R2 no wake", wk, 0);
    chk("R4 flag low", to_n, 0);
    @(negedge clk);
    chk("R2 one cycle", reset_req, 0);

    // R6 every rate with scaler on watchdog
    psa_sel = 1;
    for (int r = 0; r < 8; r++) begin
      rate = 3'(r);
      strobe(0);
      measure((BASEP << (r + 1)) + 50, n, rq, wk);
      chk($sformatf("R6 scaled period rate %0d", r), n, BASEP << (r + 1));
      chk("R2 reset raised", rq, 1);
    end

    // R6 passthrough
    @(negedge clk); tmr_src = 1; #1;
    chk("R6 passthrough high", tmr_inc, 1);
    @(negedge clk); tmr_src = 0; #1;
    chk("R6 passthrough low", tmr_inc, 0);

    // R8 clear restarts scaler when assigned to watchdog
    rate = 0;
    strobe(0);
    ticks(BASEP + 4);
    strobe(0);
    measure(4 * BASEP, n, rq, wk);
    chk("R8 scaler cleared on psa=1", n, 2 * BASEP);

    // R8 clear restarts base counter
    psa_sel = 0;
    strobe(0);
    ticks(BASEP / 2);
    strobe(0);
    measure(4 * BASEP, n, rq, wk);
    chk("R8 base cleared", n, BASEP);

    // R3 sleep wake
    asleep = 1;
    strobe(1);
    measure(4 * BASEP, n, rq, wk);
    chk("R3 wake raised", wk, 1);
    chk("R3 no reset", rq, 0);
    chk("R3 period", n, BASEP);
    chk("R4 flag low in sleep", to_n, 0);
    @(negedge clk);
    chk("R3 one cycle", wake_req, 0);
    asleep = 0;

    // R5 disabled
    strobe(0);
    wdt_en = 0;
    measure(40 * BASEP, n, rq, wk);
    chk("R5 no reset", rq, 0);
    chk("R5 no wake", wk, 0);
    chk("R5 flag stays", to_n, 1);
    wdt_en = 1;
    measure(4 * BASEP, n, rq, wk);
    chk("R5 counter held at zero", n, BASEP);

    // R7 timer division sweep
    for (int r = 0; r < 8; r++) begin
      int div, errs_before;
      div = 2 << r;
      psa_sel = 1; strobe(0);
      psa_sel = 0; rate = 3'(r);
      errs_before = errors;
      for (int i = 1; i <= 3 * div; i++) begin
        @(negedge clk); tmr_src = 1; #1;
        if (tmr_inc != ((i % div) == 0)) begin
          errors++;
          $display("FAIL R7 rate %0d pulse %0d actual %0d expected %0d", r, i, tmr_inc, (i % div) == 0);
        end
      end
      @(negedge clk); tmr_src = 0;
      checks++;
      if (errors != errs_before) $display("FAIL R7 sweep rate %0d actual bad expected clean", r);
    end

    // R8 clear does not touch scaler when assigned to timer
    psa_sel = 1; strobe(0);
    psa_sel = 0; rate = 2;
    for (int i = 0; i < 5; i++) begin @(negedge clk); tmr_src = 1; end
    @(negedge clk); tmr_src = 0; clr_wdt = 1;
    @(negedge clk); clr_wdt = 0;
    for (int i = 6; i <= 8; i++) begin
      @(negedge clk); tmr_src = 1; #1;
      chk($sformatf("R8 timer scaler kept pulse %0d", i), tmr_inc, i == 8);
    end
    @(negedge clk); tmr_src = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule